// File: doc/BRIEF.md
# Sequence-Tracked Copy Engine with Memory-Mapped Control

This block is a copy engine that a processor core drives through a small bank of 64-bit registers mapped into its address space. The core writes a source address, a destination address, two size values and a row stride, then writes a control word with a start flag. Each accepted start is given the next value of a 32-bit started-sequence counter as its transfer ID. The core can read that ID back right away.

Accepted transfers wait in a short in-order queue. A single copy engine drains the queue one 64-bit word at a time through a plain request/grant memory port. A transfer is either one-dimensional, with one contiguous run, or two-dimensional, with several rows gathered from a strided source into a packed destination. When a transfer finishes, the completed-sequence counter takes that transfer's ID. Transfers finish in start order, so one comparison against that counter covers every transfer up to a given ID.

The core has two ways to wait. It can read the completed-sequence counter until the value reaches its ID. It can also write the ID to that counter's address, and the block then holds the core's access stalled until the ID has completed.

Top module: `dmaseq_top`

## Requirements
- R1: After reset, the started and completed sequence registers read 0, `csr_stall` is low and `mem_req` is low.
- R2: Writes to the source (0x18), destination (0x20), size-0 (0x28), size-1 (0x30) and stride (0x40) offsets are read back unchanged. They leave the started-sequence value (0x08) unchanged.
- R3: A control write (offset 0x00) with bit 0 set raises the started-sequence value by one. The new value is the transfer's ID and is read back at 0x08.
- R4: When a transfer completes, the completed-sequence value (0x10) becomes its ID. Transfers complete in start order, so the value rises by one per completion and never exceeds the started-sequence value.
- R5: A write of an ID to 0x10 holds `csr_stall` high while that ID is greater than the completed-sequence value. The stall releases once the ID is reached, and the write does not change the register.
- R6: A read of any offset never asserts `csr_stall`. Polling 0x10 returns a value that rises until it covers the awaited ID.
- R7: Control bits [5:4] equal to 2 select a 2D transfer, and any other value selects 1D. Bits [7:6] and every other bit except bit 0 are ignored. A control write with bit 0 clear starts nothing. The values 0x51 and 0xA1 start a 1D and a 2D transfer.
- R8: A 1D transfer copies size-0 bytes, as 64-bit words at ascending addresses, from the source to the destination.
- R9: A 2D transfer copies size-1 rows of size-0 bytes each. The source row address advances by the stride after each row, and the destination is written contiguously.
- R10: Up to four transfers wait in the queue beside the one that is executing. A start write that finds the queue full keeps `csr_stall` high until a slot frees.
- R11: A transfer with size-0 equal to 0, or a 2D transfer with size-1 equal to 0, completes and advances the completed-sequence value without touching memory.
- R12: A memory request that is not granted stays asserted, with the same address and direction, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_req | input | 1 | Register access request, held while stalled |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 7 | Register byte offset |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Register read data, valid in the cycle of a read request |
| csr_stall | output | 1 | Access must be held; not accepted this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 64 | Byte address of the 64-bit word |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 64 | Read data, valid the cycle after a granted read |

## Verification
1D copies are swept over every length from one to eight words, each with its own source and destination, so an off-by-one in the word count or a wrong address step corrupts the destination image. 2D copies use several row, length and stride combinations, where a stride of zero rows or a stride that skips words shows whether rows advance by the stride while the destination stays packed. Part of each sweep runs with a pseudo-random grant pattern to show that data survives held requests. A run with grants withheld fills the queue, which separates correct queue depth and start-order completion from early stalls or lost transfers. Zero-length transfers and control words with ignored bits set show that the decode selects only on the start and dimension fields.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  localparam int DW  = 64;   // register and memory word width
  localparam int AW  = 64;   // address width
  localparam int LW  = 32;   // size field width
  localparam int IDW = 32;   // transfer ID width
  localparam int RAW = 7;    // register offset width
  localparam int WORD_BYTES = DW / 8;

  localparam logic [RAW-1:0] OFF_CTRL   = 7'h00;
  localparam logic [RAW-1:0] OFF_STSEQ  = 7'h08;
  localparam logic [RAW-1:0] OFF_DNSEQ  = 7'h10;
  localparam logic [RAW-1:0] OFF_SRC    = 7'h18;
  localparam logic [RAW-1:0] OFF_DST    = 7'h20;
  localparam logic [RAW-1:0] OFF_LEN0   = 7'h28;
  localparam logic [RAW-1:0] OFF_LEN1   = 7'h30;
  localparam logic [RAW-1:0] OFF_STRIDE = 7'h40;

  typedef struct packed {
    logic [IDW-1:0] id;
    logic [AW-1:0]  src;
    logic [AW-1:0]  dst;
    logic [AW-1:0]  stride;
    logic [LW-1:0]  len0;
    logic [LW-1:0]  len1;
    logic           two_d;
  } xfer_t;

  typedef enum logic [2:0] {
    E_IDLE, E_RD, E_CAP, E_WR, E_FIN
  } eng_state_e;
endpackage

// File: rtl/dmaseq_fifo.sv
module dmaseq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign full  = (cnt_q == FULLC);
  assign empty = (cnt_q == '0);
  assign dout  = store_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == LAST) ? '0 : wp_q + PW'(1);
    if (pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + PW'(1);
    if (push && !pop) cnt_d = cnt_q + CW'(1);
    else if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (wp_q == PW'(g));
    always_ff @(posedge clk) begin
      if (slot_en) store_q[g] <= din;
    end
  end
endmodule

// File: rtl/dmaseq_regs.sv
module dmaseq_regs
  import dmaseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           csr_req,
  input  logic           csr_we,
  input  logic [RAW-1:0] csr_addr,
  input  logic [DW-1:0]  csr_wdata,
  output logic [DW-1:0]  csr_rdata,
  output logic           csr_stall,
  input  logic           q_full,
  output logic           push_valid,
  output xfer_t          push_xfer,
  input  logic           done_pulse,
  input  logic [IDW-1:0] done_id,
  output logic [IDW-1:0] start_seq,
  output logic [IDW-1:0] done_seq
);
  logic [AW-1:0]  src_q, dst_q, stride_q;
  logic [LW-1:0]  len0_q, len1_q;
  logic [IDW-1:0] st_q, st_d, dn_q, dn_d;
  logic wr, start_req, wait_blk;
  logic src_en, dst_en, stride_en, len0_en, len1_en;

  assign wr        = csr_req && csr_we;
  assign start_req = wr && (csr_addr == OFF_CTRL) && csr_wdata[0];
  assign wait_blk  = wr && (csr_addr == OFF_DNSEQ) && (csr_wdata[IDW-1:0] > dn_q);
  assign csr_stall = (start_req && q_full) || wait_blk;
  assign push_valid = start_req && !q_full;

  assign src_en    = wr && (csr_addr == OFF_SRC);
  assign dst_en    = wr && (csr_addr == OFF_DST);
  assign stride_en = wr && (csr_addr == OFF_STRIDE);
  assign len0_en   = wr && (csr_addr == OFF_LEN0);
  assign len1_en   = wr && (csr_addr == OFF_LEN1);

  always_comb begin
    st_d = st_q;
    dn_d = dn_q;
    if (push_valid) st_d = st_q + IDW'(1);
    if (done_pulse) dn_d = done_id;
  end

  always_comb begin
    push_xfer.id     = st_q + IDW'(1);
    push_xfer.src    = src_q;
    push_xfer.dst    = dst_q;
    push_xfer.stride = stride_q;
    push_xfer.len0   = len0_q;
    push_xfer.len1   = len1_q;
    push_xfer.two_d  = (csr_wdata[5:4] == 2'd2);
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_req && !csr_we) begin
      unique case (csr_addr)
        OFF_STSEQ:  csr_rdata = DW'(st_q);
        OFF_DNSEQ:  csr_rdata = DW'(dn_q);
        OFF_SRC:    csr_rdata = src_q;
        OFF_DST:    csr_rdata = dst_q;
        OFF_STRIDE: csr_rdata = stride_q;
        OFF_LEN0:   csr_rdata = DW'(len0_q);
        OFF_LEN1:   csr_rdata = DW'(len1_q);
        default:    csr_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      dn_q <= '0;
    end else begin
      st_q <= st_d;
      dn_q <= dn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      dst_q    <= '0;
      stride_q <= '0;
      len0_q   <= '0;
      len1_q   <= '0;
    end else begin
      if (src_en)    src_q    <= csr_wdata;
      if (dst_en)    dst_q    <= csr_wdata;
      if (stride_en) stride_q <= csr_wdata;
      if (len0_en)   len0_q   <= csr_wdata[LW-1:0];
      if (len1_en)   len1_q   <= csr_wdata[LW-1:0];
    end
  end

  assign start_seq = st_q;
  assign done_seq  = dn_q;
endmodule

// File: rtl/dmaseq_engine.sv
module dmaseq_engine
  import dmaseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           q_empty,
  input  xfer_t          q_head,
  output logic           q_pop,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_gnt,
  input  logic [DW-1:0]  mem_rdata,
  output logic           done_pulse,
  output logic [IDW-1:0] done_id
);
  localparam logic [LW-1:0] STEP_L = LW'(WORD_BYTES);
  localparam logic [AW-1:0] STEP_A = AW'(WORD_BYTES);
  localparam logic [LW-1:0] ONE_L  = LW'(1);

  eng_state_e    st_q, st_d;
  xfer_t         cur_q, cur_d;
  logic [LW-1:0] col_q, col_d, row_q, row_d;
  logic [AW-1:0] srow_q, srow_d, dptr_q, dptr_d;
  logic [DW-1:0] data_q, data_d;
  logic          row_end, last_row;

  assign row_end  = (col_q + STEP_L) >= cur_q.len0;
  assign last_row = !cur_q.two_d || ((row_q + ONE_L) >= cur_q.len1);

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    col_d  = col_q;
    row_d  = row_q;
    srow_d = srow_q;
    dptr_d = dptr_q;
    data_d = data_q;
    q_pop      = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    mem_wdata  = '0;
    done_pulse = 1'b0;
    done_id    = '0;
    unique case (st_q)
      E_IDLE: begin
        if (!q_empty) begin
          q_pop  = 1'b1;
          cur_d  = q_head;
          col_d  = '0;
          row_d  = '0;
          srow_d = q_head.src;
          dptr_d = q_head.dst;
          st_d   = ((q_head.len0 == '0) || (q_head.two_d && (q_head.len1 == '0)))
                   ? E_FIN : E_RD;
        end
      end
      E_RD: begin
        mem_req  = 1'b1;
        mem_addr = srow_q + {{(AW-LW){1'b0}}, col_q};
        if (mem_gnt) st_d = E_CAP;
      end
      E_CAP: begin
        data_d = mem_rdata;
        st_d   = E_WR;
      end
      E_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dptr_q;
        mem_wdata = data_q;
        if (mem_gnt) begin
          dptr_d = dptr_q + STEP_A;
          if (row_end) begin
            col_d  = '0;
            row_d  = row_q + ONE_L;
            srow_d = srow_q + cur_q.stride;
            st_d   = last_row ? E_FIN : E_RD;
          end else begin
            col_d = col_q + STEP_L;
            st_d  = E_RD;
          end
        end
      end
      E_FIN: begin
        done_pulse = 1'b1;
        done_id    = cur_q.id;
        st_d       = E_IDLE;
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      cur_q  <= '0;
      col_q  <= '0;
      row_q  <= '0;
      srow_q <= '0;
      dptr_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      col_q  <= col_d;
      row_q  <= row_d;
      srow_q <= srow_d;
      dptr_q <= dptr_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
  import dmaseq_pkg::*;
#(
  parameter int Q_DEPTH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           csr_req,
  input  logic           csr_we,
  input  logic [RAW-1:0] csr_addr,
  input  logic [DW-1:0]  csr_wdata,
  output logic [DW-1:0]  csr_rdata,
  output logic           csr_stall,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_gnt,
  input  logic [DW-1:0]  mem_rdata
);
  localparam int XW = $bits(xfer_t);

  logic [1:0]     rst_sync_q;
  logic           rst_core_n;
  logic           q_full, q_empty, q_push, q_pop;
  xfer_t          push_xfer, q_head;
  logic [XW-1:0]  q_dout;
  logic           done_pulse;
  logic [IDW-1:0] done_id;
  logic [IDW-1:0] start_seq, done_seq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  dmaseq_regs regs_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .csr_req    (csr_req),
    .csr_we     (csr_we),
    .csr_addr   (csr_addr),
    .csr_wdata  (csr_wdata),
    .csr_rdata  (csr_rdata),
    .csr_stall  (csr_stall),
    .q_full     (q_full),
    .push_valid (q_push),
    .push_xfer  (push_xfer),
    .done_pulse (done_pulse),
    .done_id    (done_id),
    .start_seq  (start_seq),
    .done_seq   (done_seq)
  );

  dmaseq_fifo #(.W(XW), .DEPTH(Q_DEPTH)) fifo_i (
    .clk   (clk),
    .rst_n (rst_core_n),
    .push  (q_push),
    .din   (push_xfer),
    .pop   (q_pop),
    .dout  (q_dout),
    .full  (q_full),
    .empty (q_empty)
  );
  assign q_head = xfer_t'(q_dout);

  dmaseq_engine eng_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .q_empty    (q_empty),
    .q_head     (q_head),
    .q_pop      (q_pop),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_gnt    (mem_gnt),
    .mem_rdata  (mem_rdata),
    .done_pulse (done_pulse),
    .done_id    (done_id)
  );
endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk
  import dmaseq_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           csr_req,
  input logic           csr_we,
  input logic [RAW-1:0] csr_addr,
  input logic [DW-1:0]  csr_wdata,
  input logic           csr_stall,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic           mem_gnt,
  input logic [IDW-1:0] start_seq,
  input logic [IDW-1:0] done_seq
);
  // R2: parameter writes never start a transfer
  a_r2_param_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_we && (csr_addr != OFF_CTRL)) |=> $stable(start_seq));

  // R3: an accepted start steps the started-sequence value by one
  a_r3_start_step: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_we && (csr_addr == OFF_CTRL) && csr_wdata[0] && !csr_stall)
    |=> (start_seq == $past(start_seq) + 32'd1));

  // R4: completions arrive in order, one ID at a time
  a_r4_done_step: assert property (@(posedge clk) disable iff (!rst_n)
    (done_seq != $past(done_seq)) |-> (done_seq == $past(done_seq) + 32'd1));

  // R4: nothing completes that was not started
  a_r4_done_le_start: assert property (@(posedge clk) disable iff (!rst_n)
    done_seq <= start_seq);

  // R5: a wait write is accepted only once its ID has completed
  a_r5_wait_release: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_we && (csr_addr == OFF_DNSEQ) && !csr_stall)
    |-> (csr_wdata[IDW-1:0] <= done_seq));

  // R6: reads never stall
  a_r6_read_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && !csr_we) |-> !csr_stall);

  // R12: an ungranted memory request is held unchanged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind dmaseq_top dmaseq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .csr_req   (csr_req),
  .csr_we    (csr_we),
  .csr_addr  (csr_addr),
  .csr_wdata (csr_wdata),
  .csr_stall (csr_stall),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_gnt   (mem_gnt),
  .start_seq (start_seq),
  .done_seq  (done_seq)
);

// File: tb/dmaseq_top_tb_top.sv
module dmaseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_req, csr_we;
  logic [6:0]  csr_addr;
  logic [63:0] csr_wdata, csr_rdata;
  logic        csr_stall;
  logic        mem_req, mem_we, mem_gnt;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  dmaseq_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_stall(csr_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] next_id = 0;
  logic [63:0] mem  [256];
  logic [63:0] expm [256];
  logic [1:0]  gnt_mode = 2'd1;
  logic [7:0]  lfsr = 8'h5A;

  assign mem_gnt = (gnt_mode == 2'd1) || ((gnt_mode == 2'd2) && lfsr[0]);

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr[10:3]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[10:3]];
    end
  end

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [6:0] a, input logic [63:0] d, output int stalls);
    stalls = 0;
    @(negedge clk);
    csr_req = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    #1;
    while (csr_stall) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    csr_req = 1'b0; csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [6:0] a, output logic [63:0] d, output bit stalled);
    @(negedge clk);
    csr_req = 1'b1; csr_we = 1'b0; csr_addr = a;
    #1;
    d = csr_rdata;
    stalled = csr_stall;
    @(posedge clk);
    #1;
    csr_req = 1'b0;
  endtask

  task automatic fill_mem(input int seed);
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      logic [63:0] v;
      v = (64'h9E37_79B9_7F4A_7C15 * 64'(i + seed * 977)) ^ 64'(seed);
      mem[i] <= v;
      expm[i] = v;
    end
    @(negedge clk);
  endtask

  task automatic model_copy(input int src, input int dst, input int l0, input int l1,
                            input int stride, input bit two_d);
    int rows, d;
    rows = two_d ? l1 : 1;
    d = dst;
    if (l0 == 0) rows = 0;
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < l0; c += 8) begin
        expm[d >> 3] = expm[(src + r * stride + c) >> 3];
        d += 8;
      end
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < 256; i++)
      if (bad < 0 && mem[i] !== expm[i]) bad = i;
    if (bad < 0) chk(1'b1, req, 64'd0, 64'd0);
    else chk(1'b0, req, mem[bad], expm[bad]);
  endtask

  // program, start, wait and compare one transfer
  task automatic run_xfer(input int src, input int dst, input int l0, input int l1,
                          input int stride, input logic [7:0] ctrl, input string req);
    int s;
    logic [63:0] v;
    bit st;
    csr_wr(7'h18, 64'(src), s);
    csr_wr(7'h20, 64'(dst), s);
    csr_wr(7'h28, 64'(l0), s);
    csr_wr(7'h30, 64'(l1), s);
    csr_wr(7'h40, 64'(stride), s);
    csr_wr(7'h00, 64'(ctrl), s);
    next_id++;
    csr_rd(7'h08, v, st);
    chk(v == 64'(next_id), "R3 start id", v, 64'(next_id));
    csr_wr(7'h10, 64'(next_id), s);
    csr_rd(7'h10, v, st);
    chk(v == 64'(next_id), "R4 done id", v, 64'(next_id));
    model_copy(src, dst, l0, l1, stride, ctrl[5:4] == 2'd2);
    cmp_mem(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R5 actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    logic [63:0] v;
    bit st;
    int s;
    csr_req = 1'b0; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    @(negedge clk);
    chk(!csr_stall, "R1 stall low", 64'(csr_stall), 64'd0);
    chk(!mem_req, "R1 mem_req low", 64'(mem_req), 64'd0);
    csr_rd(7'h08, v, st);
    chk(v == 0, "R1 start seq", v, 64'd0);
    csr_rd(7'h10, v, st);
    chk(v == 0, "R1 done seq", v, 64'd0);

    // R2 parameter readback, no start
    csr_wr(7'h18, 64'hDEAD_BEEF_0123_4560, s);
    csr_wr(7'h20, 64'h0000_0000_0000_0400, s);
    csr_wr(7'h28, 64'h0000_0000_0000_0038, s);
    csr_wr(7'h30, 64'h0000_0000_0000_0005, s);
    csr_wr(7'h40, 64'h0000_0000_0000_0100, s);
    csr_rd(7'h18, v, st); chk(v == 64'hDEAD_BEEF_0123_4560, "R2 src", v, 64'hDEAD_BEEF_0123_4560);
    csr_rd(7'h20, v, st); chk(v == 64'h400, "R2 dst", v, 64'h400);
    csr_rd(7'h28, v, st); chk(v == 64'h38, "R2 len0", v, 64'h38);
    csr_rd(7'h30, v, st); chk(v == 64'h5, "R2 len1", v, 64'h5);
    csr_rd(7'h40, v, st); chk(v == 64'h100, "R2 stride", v, 64'h100);
    csr_rd(7'h08, v, st); chk(v == 0, "R2 no start", v, 64'd0);

    // R7 control without start bit
    csr_wr(7'h00, 64'hFFFF_FFFF_FFFF_FFF0, s);
    repeat (3) @(posedge clk);
    csr_rd(7'h08, v, st); chk(v == 0, "R7 no start bit", v, 64'd0);
    chk(!mem_req, "R7 idle memory", 64'(mem_req), 64'd0);

    // R8 1D sweep over every length 1..8 words
    fill_mem(1);
    for (int n = 1; n <= 8; n++) begin
      gnt_mode = (n > 4) ? 2'd2 : 2'd1;
      run_xfer(n * 16, 1024 + (n - 1) * 64, n * 8, 0, 0, 8'h51, "R8 1D copy");
    end
    gnt_mode = 2'd1;

    // R9 2D combinations, R7 ignored bits
    fill_mem(2);
    run_xfer(0,   1536, 16, 3, 48, 8'hA1, "R9 2D rows stride");
    run_xfer(256, 1664, 8,  4, 24, 8'hE1, "R7 R9 2D kind ignored");
    gnt_mode = 2'd2;
    run_xfer(512, 1792, 24, 2, 64, 8'h21, "R9 2D random grant");
    run_xfer(64,  1920, 16, 2, 0,  8'hA1, "R9 2D zero stride");
    gnt_mode = 2'd1;
    run_xfer(128, 1280, 32, 7, 0,  8'h31, "R7 dim3 is 1D");
    run_xfer(200, 1400, 8,  0, 0,  8'hD1, "R7 dim1 kind ignored");

    // R11 zero length
    fill_mem(3);
    run_xfer(0, 1024, 0, 3, 8, 8'h51, "R11 zero len0 1D");
    run_xfer(0, 1024, 16, 0, 8, 8'hA1, "R11 zero len1 2D");

    // R10 queue depth, R6 reads during stall conditions, R4 order
    fill_mem(4);
    gnt_mode = 2'd0;
    csr_wr(7'h18, 64'd0, s);
    csr_wr(7'h28, 64'd8, s);
    for (int k = 0; k < 5; k++) begin
      csr_wr(7'h20, 64'(1024 + k * 8), s);
      csr_wr(7'h00, 64'h51, s);
      chk(s == 0, "R10 start accepted", 64'(s), 64'd0);
      model_copy(0, 1024 + k * 8, 8, 0, 0, 1'b0);
    end
    csr_wr(7'h20, 64'(1024 + 40), s);
    @(negedge clk);
    csr_req = 1'b1; csr_we = 1'b1; csr_addr = 7'h00; csr_wdata = 64'h51;
    #1;
    chk(csr_stall, "R10 full queue stalls", 64'(csr_stall), 64'd1);
    @(negedge clk);
    #1;
    chk(csr_stall, "R10 stall held", 64'(csr_stall), 64'd1);
    csr_req = 1'b0; csr_we = 1'b0;
    csr_rd(7'h10, v, st);
    chk(!st, "R6 read no stall", 64'(st), 64'd0);
    chk(v == 64'(next_id), "R6 done before grant", v, 64'(next_id));
    gnt_mode = 2'd2;
    csr_wr(7'h00, 64'h51, s);
    model_copy(0, 1024 + 40, 8, 0, 0, 1'b0);
    next_id += 6;
    csr_rd(7'h08, v, st);
    chk(v == 64'(next_id), "R3 six ids", v, 64'(next_id));
    csr_wr(7'h10, 64'(next_id), s);
    chk(s > 0, "R5 wait stalls", 64'(s), 64'd1);
    csr_rd(7'h10, v, st);
    chk(v == 64'(next_id), "R4 all complete", v, 64'(next_id));
    cmp_mem("R10 queued copies");
    gnt_mode = 2'd1;

    // R5 wait on an older ID does not stall and changes nothing
    csr_wr(7'h10, 64'(next_id - 3), s);
    chk(s == 0, "R5 old id no stall", 64'(s), 64'd0);
    csr_rd(7'h10, v, st);
    chk(v == 64'(next_id), "R5 wait leaves value", v, 64'(next_id));

    // R6 polling a long transfer
    begin
      logic [63:0] last;
      int polls;
      bit mono;
      csr_wr(7'h18, 64'd0, s);
      csr_wr(7'h20, 64'd1024, s);
      csr_wr(7'h28, 64'd128, s);
      csr_wr(7'h00, 64'h51, s);
      next_id++;
      model_copy(0, 1024, 128, 0, 0, 1'b0);
      last = 0; polls = 0; mono = 1'b1;
      v = 0;
      while (v < 64'(next_id) && polls < 1000) begin
        csr_rd(7'h10, v, st);
        if (st) mono = 1'b0;
        if (v < last) mono = 1'b0;
        last = v;
        polls++;
      end
      chk(mono, "R6 polling no stall rising", 64'(mono), 64'd1);
      chk(polls > 1, "R6 poll saw pending", 64'(polls), 64'd2);
      chk(v == 64'(next_id), "R6 poll reached id", v, 64'(next_id));
      cmp_mem("R8 polled copy");
    end

    report();
    $finish;
  end
endmodule